// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block watches the address phase of each I2C transfer and decides whether the local device is being addressed. It receives whole bytes from a bit-level receiver, one `byte_valid_i` strobe per byte, and a `start_i` pulse for every start or repeated start. It compares the first byte, and for 10-bit addressing also the second byte, against three programmable address slots. It also checks a small set of reserved addresses. Each slot can be switched on or off. Each slot can be set to 7-bit or 10-bit format on its own, so both formats can be in use at the same time.

When the address phase completes with a hit, the block does four things. It pulses an acknowledge request. It records which slot matched, or which reserved address was seen. It latches the read/write direction. It pulses either the receive-full or the transmit-empty indication, depending on that direction. A 10-bit header byte that is still only a candidate is acknowledged without completing. A slot that was matched for writing in 10-bit form can then be re-addressed for reading after a repeated start, using the header byte alone. Once the address phase is over, all bytes are ignored until the next start. All outputs are registered, so results appear one clock after the strobe.

Top module: `i2c_addr_match`

## Requirements
- R1: After synchronous reset every output is 0, and bytes arriving before the first `start_i` are ignored (no acknowledge, no match).
- R2: On the first byte after a start, an enabled 7-bit slot matches when byte bits [7:1] equal its address bits [6:0]. The block then pulses `ack_o` and `done_o`, sets `slot_vld_o`, reports the slot index on `slot_o` and latches byte bit 0 as `rw_o` (1 = read).
- R3: A slot whose enable bit is 0 never matches, in either format.
- R4: A 10-bit write match takes two bytes. The first byte is binary 11110, then address bits [9:8], then 0; it is acknowledged with `ack_o` only, without `done_o`. The second byte must equal address bits [7:0], and completes the match with `rw_o` = 0. A wrong second byte gives neither acknowledge nor match.
- R5: After a 10-bit write match, a repeated start followed by header byte 11110, [9:8], 1 completes a read match on that same slot in one byte. Any other first byte after a start cancels this right. A read header with no preceding write match is not acknowledged.
- R6: Slots in 7-bit and 10-bit format work side by side. When several slots match the same byte, the lowest slot index is reported.
- R7: Each completed match pulses `rx_full_o` for one cycle when `rw_o` = 0, or `tx_empty_o` when `rw_o` = 1, always in the same cycle as `done_o`.
- R8: With the general-call enable set, first byte 0x00 completes a match with `gc_o` = 1 and `rw_o` = 0. Byte 0x01 does not match. With the enable clear, 0x00 is not acknowledged.
- R9: With the device-ID enable set, a first byte whose bits [7:1] are 1111100 completes a match with `devid_o` = 1 and either direction.
- R10: With the host-address enable set, a first byte whose bits [7:1] are 0001000 completes a match with `host_o` = 1 and either direction.
- R11: `start_i` clears `slot_vld_o`, `rw_o` and the three reserved-address flags on the next cycle. Bytes after a completed address phase leave all outputs unchanged apart from the one-cycle pulses, which stay 0.
- R12: A first byte that matches nothing is not acknowledged, and every later byte is ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse on start or repeated start; takes precedence over a byte in the same cycle |
| byte_valid_i | input | 1 | Strobe: `byte_i` holds a received byte |
| byte_i | input | 8 | Received byte, MSB first on the wire |
| slot_en_i | input | NUM_SLOTS | Per-slot enable |
| slot_10b_i | input | NUM_SLOTS | Per-slot format, 1 = 10-bit |
| slot_addr_i | input | NUM_SLOTS*10 | Slot i address at bits [i*10 +: 10]; 7-bit slots use the low 7 bits |
| gc_en_i | input | 1 | Enable general-call detection |
| devid_en_i | input | 1 | Enable device-ID detection |
| host_en_i | input | 1 | Enable host-address detection |
| ack_o | output | 1 | One-cycle request to acknowledge the byte just received |
| done_o | output | 1 | One-cycle pulse: address phase completed with a match |
| rx_full_o | output | 1 | One-cycle pulse on a completed write match |
| tx_empty_o | output | 1 | One-cycle pulse on a completed read match |
| slot_vld_o | output | 1 | A programmable slot matched in this transfer |
| slot_o | output | SLOT_W | Index of the matched slot |
| rw_o | output | 1 | Direction of the matched transfer, 1 = read |
| gc_o | output | 1 | General-call address seen |
| devid_o | output | 1 | Device-ID address seen |
| host_o | output | 1 | Host address seen |

## Verification
The hardest situation to reach from the ports is the 10-bit read that relies on state left behind by an earlier transfer. The remembered slot must survive a repeated start and be spent by an unrelated first byte. The bench reaches it by first completing a two-byte write match, then issuing a start and the read header alone. It then cancels the right with a 7-bit match, and shows that the same read header is refused afterwards. Priority is reached by reprogramming a second slot to the same 7-bit address and then disabling slots one at a time.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int ADDR_W = 10;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FIRST,
    PH_SECOND,
    PH_DATA
  } phase_e;

  localparam logic [4:0] HDR10      = 5'b11110;
  localparam logic [6:0] GC_ADDR    = 7'b0000000;
  localparam logic [6:0] DEVID_ADDR = 7'b1111100;
  localparam logic [6:0] HOST_ADDR  = 7'b0001000;
endpackage

// File: rtl/i2c_am_slot_cmp.sv
module i2c_am_slot_cmp
  import i2c_am_pkg::*;
(
  input  logic              en_i,
  input  logic              is10_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        byte_i,
  output logic              hit7_o,
  output logic              hdr_w_o,
  output logic              hdr_r_o,
  output logic              low_eq_o
);
  logic hdr_match;

  always_comb begin
    hdr_match = (byte_i[7:3] == HDR10) && (byte_i[2:1] == addr_i[9:8]);
    hit7_o    = en_i && !is10_i && (byte_i[7:1] == addr_i[6:0]);
    hdr_w_o   = en_i && is10_i && hdr_match && !byte_i[0];
    hdr_r_o   = en_i && is10_i && hdr_match && byte_i[0];
    low_eq_o  = en_i && is10_i && (byte_i == addr_i[7:0]);
  end
endmodule

// File: rtl/i2c_am_prio.sv
module i2c_am_prio #(
  parameter int N      = 3,
  parameter int IDX_W  = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  always_comb begin
    any_o    = |req_i;
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o    = IDX_W'(i);
        onehot_o = '0;
        onehot_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_am_special.sv
module i2c_am_special
  import i2c_am_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic       gc_en_i,
  input  logic       devid_en_i,
  input  logic       host_en_i,
  output logic       gc_o,
  output logic       devid_o,
  output logic       host_o
);
  always_comb begin
    gc_o    = gc_en_i && (byte_i[7:1] == GC_ADDR) && !byte_i[0];
    devid_o = devid_en_i && (byte_i[7:1] == DEVID_ADDR);
    host_o  = host_en_i && (byte_i[7:1] == HOST_ADDR);
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic                        byte_valid_i,
  input  logic [7:0]                  byte_i,
  input  logic [NUM_SLOTS-1:0]        slot_en_i,
  input  logic [NUM_SLOTS-1:0]        slot_10b_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_i,
  input  logic                        gc_en_i,
  input  logic                        devid_en_i,
  input  logic                        host_en_i,
  output logic                        ack_o,
  output logic                        done_o,
  output logic                        rx_full_o,
  output logic                        tx_empty_o,
  output logic                        slot_vld_o,
  output logic [SLOT_W-1:0]           slot_o,
  output logic                        rw_o,
  output logic                        gc_o,
  output logic                        devid_o,
  output logic                        host_o
);
  logic [NUM_SLOTS-1:0] hit7, hdr_w, hdr_r, low_eq;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    i2c_am_slot_cmp u_cmp (
      .en_i     (slot_en_i[g]),
      .is10_i   (slot_10b_i[g]),
      .addr_i   (slot_addr_i[g*ADDR_W +: ADDR_W]),
      .byte_i   (byte_i),
      .hit7_o   (hit7[g]),
      .hdr_w_o  (hdr_w[g]),
      .hdr_r_o  (hdr_r[g]),
      .low_eq_o (low_eq[g])
    );
  end

  phase_e               phase;
  logic [NUM_SLOTS-1:0] cand;
  logic [NUM_SLOTS-1:0] last10;

  logic [NUM_SLOTS-1:0] rd_req, sec_req;
  logic                 any7, anyrd, anysec;
  logic [SLOT_W-1:0]    idx7, idxrd, idxsec;
  logic [NUM_SLOTS-1:0] oh7, ohrd, ohsec;

  assign rd_req  = last10 & hdr_r;
  assign sec_req = cand & low_eq;

  i2c_am_prio #(.N(NUM_SLOTS), .IDX_W(SLOT_W)) u_prio7 (
    .req_i(hit7), .any_o(any7), .idx_o(idx7), .onehot_o(oh7)
  );
  i2c_am_prio #(.N(NUM_SLOTS), .IDX_W(SLOT_W)) u_priord (
    .req_i(rd_req), .any_o(anyrd), .idx_o(idxrd), .onehot_o(ohrd)
  );
  i2c_am_prio #(.N(NUM_SLOTS), .IDX_W(SLOT_W)) u_priosec (
    .req_i(sec_req), .any_o(anysec), .idx_o(idxsec), .onehot_o(ohsec)
  );

  logic sp_gc, sp_devid, sp_host, sp_any;

  i2c_am_special u_special (
    .byte_i     (byte_i),
    .gc_en_i    (gc_en_i),
    .devid_en_i (devid_en_i),
    .host_en_i  (host_en_i),
    .gc_o       (sp_gc),
    .devid_o    (sp_devid),
    .host_o     (sp_host)
  );
  assign sp_any = sp_gc | sp_devid | sp_host;

  logic unused_oh;
  assign unused_oh = |{oh7, ohrd};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cand       <= '0;
      last10     <= '0;
      ack_o      <= 1'b0;
      done_o     <= 1'b0;
      rx_full_o  <= 1'b0;
      tx_empty_o <= 1'b0;
      slot_vld_o <= 1'b0;
      slot_o     <= '0;
      rw_o       <= 1'b0;
      gc_o       <= 1'b0;
      devid_o    <= 1'b0;
      host_o     <= 1'b0;
    end else begin
      ack_o      <= 1'b0;
      done_o     <= 1'b0;
      rx_full_o  <= 1'b0;
      tx_empty_o <= 1'b0;
      if (start_i) begin
        phase      <= PH_FIRST;
        cand       <= '0;
        slot_vld_o <= 1'b0;
        slot_o     <= '0;
        rw_o       <= 1'b0;
        gc_o       <= 1'b0;
        devid_o    <= 1'b0;
        host_o     <= 1'b0;
      end else if (byte_valid_i) begin
        unique case (phase)
          PH_FIRST: begin
            last10  <= '0;
            gc_o    <= sp_gc;
            devid_o <= sp_devid;
            host_o  <= sp_host;
            phase   <= PH_DATA;
            if (anyrd) begin
              last10     <= last10;
              ack_o      <= 1'b1;
              done_o     <= 1'b1;
              tx_empty_o <= 1'b1;
              rw_o       <= 1'b1;
              slot_vld_o <= 1'b1;
              slot_o     <= idxrd;
            end else if (any7 || sp_any) begin
              ack_o      <= 1'b1;
              done_o     <= 1'b1;
              rx_full_o  <= !byte_i[0];
              tx_empty_o <= byte_i[0];
              rw_o       <= byte_i[0];
              slot_vld_o <= any7;
              slot_o     <= any7 ? idx7 : '0;
            end else if (|hdr_w) begin
              ack_o <= 1'b1;
              cand  <= hdr_w;
              phase <= PH_SECOND;
            end
          end
          PH_SECOND: begin
            phase <= PH_DATA;
            cand  <= '0;
            if (anysec) begin
              ack_o      <= 1'b1;
              done_o     <= 1'b1;
              rx_full_o  <= 1'b1;
              rw_o       <= 1'b0;
              slot_vld_o <= 1'b1;
              slot_o     <= idxsec;
              last10     <= ohsec;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk #(
  parameter int NUM_SLOTS = 3,
  parameter int SLOT_W    = 2
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic byte_valid_i,
  input logic ack_o,
  input logic done_o,
  input logic rx_full_o,
  input logic tx_empty_o,
  input logic slot_vld_o,
  input logic rw_o,
  input logic gc_o,
  input logic devid_o,
  input logic host_o
);
  assert_done_acks_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ack_o);

  assert_one_dir_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rx_full_o ^ tx_empty_o));

  assert_rx_write_R7: assert property (@(posedge clk) disable iff (rst)
    rx_full_o |-> !rw_o);

  assert_tx_read_R7: assert property (@(posedge clk) disable iff (rst)
    tx_empty_o |-> rw_o);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_start_clears_R11: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !(slot_vld_o || gc_o || devid_o || host_o || rw_o || ack_o));

  assert_ack_needs_byte_R12: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(byte_valid_i));

  assert_gc_write_R8: assert property (@(posedge clk) disable iff (rst)
    gc_o |-> !rw_o);

  assert_slot_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(slot_vld_o) |-> done_o);
endmodule

bind i2c_addr_match i2c_am_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .byte_valid_i (byte_valid_i),
  .ack_o        (ack_o),
  .done_o       (done_o),
  .rx_full_o    (rx_full_o),
  .tx_empty_o   (tx_empty_o),
  .slot_vld_o   (slot_vld_o),
  .rw_o         (rw_o),
  .gc_o         (gc_o),
  .devid_o      (devid_o),
  .host_o       (host_o)
);

// File: tb/i2c_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_addr_match_tb;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [NS-1:0] slot_en_i;
  logic [NS-1:0] slot_10b_i;
  logic [NS*10-1:0] slot_addr_i;
  logic gc_en_i = 1'b0, devid_en_i = 1'b0, host_en_i = 1'b0;
  logic ack_o, done_o, rx_full_o, tx_empty_o, slot_vld_o, rw_o, gc_o, devid_o, host_o;
  logic [1:0] slot_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  i2c_addr_match #(.NUM_SLOTS(NS)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .byte_valid_i(byte_valid_i),
    .byte_i(byte_i), .slot_en_i(slot_en_i), .slot_10b_i(slot_10b_i),
    .slot_addr_i(slot_addr_i), .gc_en_i(gc_en_i), .devid_en_i(devid_en_i),
    .host_en_i(host_en_i), .ack_o(ack_o), .done_o(done_o), .rx_full_o(rx_full_o),
    .tx_empty_o(tx_empty_o), .slot_vld_o(slot_vld_o), .slot_o(slot_o), .rw_o(rw_o),
    .gc_o(gc_o), .devid_o(devid_o), .host_o(host_o)
  );

  // packing: {ack, done, rx_full, tx_empty, slot_vld, slot[1:0], rw, gc, devid, host}
  task automatic chk(input string tag, input logic [10:0] exp);
    logic [10:0] act;
    act = {ack_o, done_o, rx_full_o, tx_empty_o, slot_vld_o, slot_o, rw_o, gc_o, devid_o, host_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] b);
    @(negedge clk); byte_valid_i = 1'b1; byte_i = b;
    @(negedge clk); byte_valid_i = 1'b0;
  endtask

  task automatic default_cfg();
    slot_en_i   = 3'b011;
    slot_10b_i  = 3'b001;
    slot_addr_i = {10'h000, 10'h03C, 10'h2A5};
    gc_en_i = 1'b0; devid_en_i = 1'b0; host_en_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset state", 11'b0_0_0_0_0_00_0_000);
    do_byte(8'h78);
    chk("R1 byte before start ignored", 11'b0_0_0_0_0_00_0_000);
  endtask

  task automatic t_7bit();
    do_start();
    do_byte(8'h78);
    chk("R2 R7 7-bit write match slot1", 11'b1_1_1_0_1_01_0_000);
    do_byte(8'h78);
    chk("R11 data byte ignored", 11'b0_0_0_0_1_01_0_000);
    do_start();
    chk("R11 start clears", 11'b0_0_0_0_0_00_0_000);
    do_byte(8'h79);
    chk("R2 R7 7-bit read match slot1", 11'b1_1_0_1_1_01_1_000);
  endtask

  task automatic t_10bit();
    do_start();
    do_byte(8'hF4);
    chk("R4 10-bit header acked only", 11'b1_0_0_0_0_00_0_000);
    do_byte(8'hA6);
    chk("R4 wrong low byte", 11'b0_0_0_0_0_00_0_000);
    do_start();
    do_byte(8'hF4);
    do_byte(8'hA5);
    chk("R4 R6 10-bit write match slot0", 11'b1_1_1_0_1_00_0_000);
  endtask

  task automatic t_10read();
    do_start();
    do_byte(8'hF5);
    chk("R5 restart read header", 11'b1_1_0_1_1_00_1_000);
    do_start();
    do_byte(8'h78);
    chk("R6 7-bit after 10-bit", 11'b1_1_1_0_1_01_0_000);
    do_start();
    do_byte(8'hF5);
    chk("R5 read right cancelled", 11'b0_0_0_0_0_00_0_000);
  endtask

  task automatic t_prio();
    slot_en_i = 3'b111;
    slot_addr_i[29:20] = 10'h03C;
    do_start();
    do_byte(8'h78);
    chk("R6 lowest slot wins", 11'b1_1_1_0_1_01_0_000);
    slot_en_i = 3'b101;
    do_start();
    do_byte(8'h78);
    chk("R3 disabled slot1 skipped", 11'b1_1_1_0_1_10_0_000);
    slot_en_i = 3'b001;
    do_start();
    do_byte(8'h78);
    chk("R3 all 7-bit slots disabled", 11'b0_0_0_0_0_00_0_000);
    slot_en_i = 3'b000;
    do_start();
    do_byte(8'hF4);
    chk("R3 disabled 10-bit slot", 11'b0_0_0_0_0_00_0_000);
    default_cfg();
  endtask

  task automatic t_special();
    gc_en_i = 1'b1;
    do_start();
    do_byte(8'h00);
    chk("R8 general call", 11'b1_1_1_0_0_00_0_100);
    do_start();
    do_byte(8'h01);
    chk("R8 0x01 not matched", 11'b0_0_0_0_0_00_0_000);
    gc_en_i = 1'b0;
    do_start();
    do_byte(8'h00);
    chk("R8 general call disabled", 11'b0_0_0_0_0_00_0_000);
    devid_en_i = 1'b1;
    do_start();
    do_byte(8'hF9);
    chk("R9 device ID read", 11'b1_1_0_1_0_00_1_010);
    devid_en_i = 1'b0;
    do_start();
    do_byte(8'hF8);
    chk("R9 device ID disabled", 11'b0_0_0_0_0_00_0_000);
    host_en_i = 1'b1;
    do_start();
    do_byte(8'h10);
    chk("R10 host address write", 11'b1_1_1_0_0_00_0_001);
    host_en_i = 1'b0;
    do_start();
    do_byte(8'h11);
    chk("R10 host address disabled", 11'b0_0_0_0_0_00_0_000);
  endtask

  task automatic t_unmatched();
    do_start();
    do_byte(8'h22);
    chk("R12 unmatched first byte", 11'b0_0_0_0_0_00_0_000);
    do_byte(8'h78);
    chk("R12 later byte ignored", 11'b0_0_0_0_0_00_0_000);
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    default_cfg();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_7bit();
    t_10bit();
    t_10read();
    t_prio();
    t_special();
    t_unmatched();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule